// File: doc/BRIEF.md
# BCD calendar timekeeping core

This block keeps wall-clock time and date in packed BCD registers and advances by one second for each accepted 1 Hz tick. It keeps seconds, minutes, 24-hour hours, day of month, weekday, month and a two-digit year. Carries ripple through the whole calendar, using the true length of each month and a leap-year rule for February. A century bit in the month register flips each time the year wraps.

A host reaches the core through a flat byte register port. Each write takes effect on a clock edge, and reads are combinational. To load a new time, the host first sets the halt bit in the first control register. It then writes the seven time bytes, seconds first, and finally clears the halt bit. While halted, the seconds prescaler is held clear. Because of this, the first tick after release only completes the partial second, and the time moves on the tick after that. A power-fail input sets a sticky flag in the seconds register that marks the calendar as untrustworthy. The next seconds write clears it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 0x80 (invalid flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, and both control registers 0x00.
- R2: The address map is 0x0 control1, 0x1 control2, 0x2 seconds, 0x3 minutes, 0x4 hours, 0x5 day, 0x6 weekday, 0x7 month, 0x8 year. Bits above the field width read 0: seconds and minutes hold 7 bits, hours and day 6, weekday 3, month 5 plus the century flag in bit 7, and control1 holds only bit 5. Addresses 0x9 to 0xF read 0 and ignore writes.
- R3: On an accepted tick, seconds step in BCD and wrap from 0x59 to 0x00, carrying into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: The day wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in every other month except February. On that wrap the month steps.
- R5: In February the day wraps after 0x29 when the year (as a decimal number) is a multiple of 4, and after 0x28 otherwise.
- R6: The month wraps from 0x12 to 0x01 and steps the year. The year wraps from 0x99 to 0x00, and that wrap inverts month bit 7 (the century flag).
- R7: Weekday steps with every day change and wraps from 6 to 0.
- R8: While control1 bit 5 (halt) is 1, ticks change no time register.
- R9: After reset, or after halt returns to 0, the first tick is absorbed without changing the time, and each later tick advances one second.
- R10: A pulse on pwr_fail sets seconds bit 7. A write to seconds clears it whatever data bit 7 holds, but pwr_fail in the same cycle wins. The time fields are not disturbed by either.
- R11: A tick arriving in the same cycle as any register write is dropped. It neither advances the time nor is absorbed.
- R12: Control2 is a plain storage byte of which bits 4:0 are kept and bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| pwr_fail | input | 1 | Power-fail indication, sets the invalid flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
The range checks on seconds and day assume that the host writes only legal packed BCD into the time registers, so that seconds never exceed 0x59 and the day is never 0x00. The bench keeps to this: the only illegal values it writes go to hours, day (nonzero), weekday and the control registers, as a test of the read masks. A full legal time is reloaded before any counting follows. The century check assumes ticks are single-cycle pulses at least two cycles apart, and every tick the bench issues is a one-cycle pulse separated by idle cycles.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          pwr_fail,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam logic [AW-1:0] A_CTL1 = AW'(0);
  localparam logic [AW-1:0] A_CTL2 = AW'(1);
  localparam logic [AW-1:0] A_SEC  = AW'(2);
  localparam logic [AW-1:0] A_MIN  = AW'(3);
  localparam logic [AW-1:0] A_HR   = AW'(4);
  localparam logic [AW-1:0] A_DAY  = AW'(5);
  localparam logic [AW-1:0] A_WDAY = AW'(6);
  localparam logic [AW-1:0] A_MON  = AW'(7);
  localparam logic [AW-1:0] A_YR   = AW'(8);

  logic       halt_q, skip_q, vl_q, cent_q;
  logic [4:0] ctl2_q, mon_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, day_q, dim;
  logic [2:0] wday_q;
  logic [7:0] yr_q, yr_bin;
  logic [7:0] sec_inc, min_inc, hr_inc, day_inc, mon_inc, yr_inc;

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign sec_inc = bcd_next({1'b0, sec_q});
  assign min_inc = bcd_next({1'b0, min_q});
  assign hr_inc  = bcd_next({2'b0, hr_q});
  assign day_inc = bcd_next({2'b0, day_q});
  assign mon_inc = bcd_next({3'b0, mon_q});
  assign yr_inc  = bcd_next(yr_q);

  assign yr_bin = 8'(yr_q[7:4]) * 8'd10 + 8'(yr_q[3:0]);
  wire leap = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (mon_q)
      5'h02:                      dim = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dim = 6'h30;
      default:                    dim = 6'h31;
    endcase
  end

  wire step    = tick_1hz && !halt_q && !wr_en && !skip_q;
  wire sec_end = sec_q >= 7'h59;
  wire min_end = min_q >= 7'h59;
  wire hr_end  = hr_q >= 6'h23;
  wire day_end = day_q >= dim;
  wire mon_end = mon_q >= 5'h12;
  wire yr_end  = yr_q >= 8'h99;
  wire c_min   = step && sec_end;
  wire c_hr    = c_min && min_end;
  wire c_day   = c_hr && hr_end;
  wire c_mon   = c_day && day_end;
  wire c_yr    = c_mon && mon_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      skip_q <= 1'b1;
      vl_q   <= 1'b1;
      cent_q <= 1'b0;
      ctl2_q <= '0;
      sec_q  <= '0;
      min_q  <= '0;
      hr_q   <= '0;
      day_q  <= 6'h01;
      wday_q <= '0;
      mon_q  <= 5'h01;
      yr_q   <= '0;
    end else begin
      if (halt_q)                 skip_q <= 1'b1;
      else if (tick_1hz && !wr_en) skip_q <= 1'b0;

      if (step)  sec_q <= sec_end ? 7'h00 : sec_inc[6:0];
      if (c_min) min_q <= min_end ? 7'h00 : min_inc[6:0];
      if (c_hr)  hr_q  <= hr_end ? 6'h00 : hr_inc[5:0];
      if (c_day) begin
        day_q  <= day_end ? 6'h01 : day_inc[5:0];
        wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
      end
      if (c_mon) mon_q <= mon_end ? 5'h01 : mon_inc[4:0];
      if (c_yr) begin
        yr_q <= yr_end ? 8'h00 : yr_inc;
        if (yr_end) cent_q <= ~cent_q;
      end

      if (wr_en) begin
        case (addr)
          A_CTL1: halt_q <= wdata[5];
          A_CTL2: ctl2_q <= wdata[4:0];
          A_SEC:  sec_q  <= wdata[6:0];
          A_MIN:  min_q  <= wdata[6:0];
          A_HR:   hr_q   <= wdata[5:0];
          A_DAY:  day_q  <= wdata[5:0];
          A_WDAY: wday_q <= wdata[2:0];
          A_MON:  begin mon_q <= wdata[4:0]; cent_q <= wdata[7]; end
          A_YR:   yr_q   <= wdata;
          default: ;
        endcase
      end

      if (pwr_fail)                      vl_q <= 1'b1;
      else if (wr_en && addr == A_SEC)   vl_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTL1:  rdata = {2'b0, halt_q, 5'b0};
      A_CTL2:  rdata = {3'b0, ctl2_q};
      A_SEC:   rdata = {vl_q, sec_q};
      A_MIN:   rdata = {1'b0, min_q};
      A_HR:    rdata = {2'b0, hr_q};
      A_DAY:   rdata = {2'b0, day_q};
      A_WDAY:  rdata = {5'b0, wday_q};
      A_MON:   rdata = {cent_q, 2'b0, mon_q};
      A_YR:    rdata = yr_q;
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          halt_q,
  input logic          skip_q,
  input logic          vl_q,
  input logic          cent_q,
  input logic [6:0]    sec_q,
  input logic [6:0]    min_q,
  input logic [5:0]    day_q,
  input logic [7:0]    yr_q
);

  localparam logic [AW-1:0] A_SEC = AW'(2);

  a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(day_q)));

  a_r9_absorb_keeps_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && !(wr_en && addr == A_SEC)) |=> $stable(sec_q));

  a_r10_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> vl_q);

  a_r10_sec_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEC && !pwr_fail) |=> !vl_q);

  a_r11_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_SEC) |=> $stable(sec_q));

  a_r3_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[3:0] <= 4'd9) && (sec_q <= 7'h59));

  a_r4_day_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    day_q != 6'h00);

  a_r6_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(yr_q) == 8'h99 && yr_q == 8'h00) |-> (cent_q != $past(cent_q)));

endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wr_en(wr_en), .addr(addr),
  .halt_q(halt_q), .skip_q(skip_q), .vl_q(vl_q), .cent_q(cent_q),
  .sec_q(sec_q), .min_q(min_q), .day_q(day_q), .yr_q(yr_q)
);

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  logic       clk = 0, rst_n = 0, tick_1hz = 0, pwr_fail = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  bcd_rtc_core #(.AW(4)) uut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .pwr_fail(pwr_fail), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic expect_reg(string req, int a, logic [7:0] exp);
    addr = 4'(a);
    #1;
    nchk++;
    if (rdata !== exp) begin
      nbad++;
      $display("FAIL %s addr=%0h got=%02h exp=%02h", req, a, rdata, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tk();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d,
                          logic [7:0] w, logic [7:0] mo, logic [7:0] y);
    wr(0, 8'h20); wr(2, s); wr(3, m); wr(4, h); wr(5, d); wr(6, w); wr(7, mo); wr(8, y);
    wr(0, 8'h00);
    tk();
  endtask

  task automatic t_reset();
    expect_reg("R1", 2, 8'h80); expect_reg("R1", 3, 8'h00); expect_reg("R1", 4, 8'h00);
    expect_reg("R1", 5, 8'h01); expect_reg("R1", 6, 8'h00); expect_reg("R1", 7, 8'h01);
    expect_reg("R1", 8, 8'h00); expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00);
    tk(); expect_reg("R9 first tick after reset", 2, 8'h80);
    tk(); expect_reg("R9 second tick after reset", 2, 8'h81);
  endtask

  task automatic t_masks();
    wr(4, 8'hFF); expect_reg("R2 hours mask", 4, 8'h3F);
    wr(5, 8'hFF); expect_reg("R2 day mask", 5, 8'h3F);
    wr(6, 8'hFF); expect_reg("R2 weekday mask", 6, 8'h07);
    wr(0, 8'hFF); expect_reg("R2 control1 mask", 0, 8'h20);
    wr(0, 8'h00);
    wr(10, 8'hFF); expect_reg("R2 unmapped", 10, 8'h00);
    wr(1, 8'hFF); expect_reg("R12 control2", 1, 8'h1F);
    wr(1, 8'h0A); expect_reg("R12 control2", 1, 8'h0A);
  endtask

  task automatic t_full_wrap();
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
    expect_reg("R9 absorbed", 2, 8'h59);
    tk();
    expect_reg("R3 sec", 2, 8'h00); expect_reg("R3 min", 3, 8'h00); expect_reg("R3 hour", 4, 8'h00);
    expect_reg("R4 day", 5, 8'h01); expect_reg("R7 weekday", 6, 8'h00);
    expect_reg("R6 month+century", 7, 8'h81); expect_reg("R6 year", 8, 8'h00);
  endtask

  task automatic t_minute_carry();
    set_time(8'h59, 8'h14, 8'h10, 8'h05, 8'h02, 8'h03, 8'h21);
    tk();
    expect_reg("R3 sec", 2, 8'h00); expect_reg("R3 min", 3, 8'h15); expect_reg("R3 hour", 4, 8'h10);
    expect_reg("R7 weekday steady", 6, 8'h02);
    tk(); expect_reg("R3 sec step", 2, 8'h01);
  endtask

  task automatic t_month_len();
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h03, 8'h04, 8'h21);
    tk(); expect_reg("R4 april end", 5, 8'h01); expect_reg("R4 april->may", 7, 8'h05);
    expect_reg("R7 weekday", 6, 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h03, 8'h01, 8'h21);
    tk(); expect_reg("R4 jan 31", 5, 8'h31); expect_reg("R4 jan stays", 7, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h03, 8'h11, 8'h21);
    tk(); expect_reg("R4 nov end", 5, 8'h01); expect_reg("R4 nov->dec", 7, 8'h12);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h03, 8'h12, 8'h21);
    tk(); expect_reg("R6 dec->jan", 7, 8'h01); expect_reg("R6 year step", 8, 8'h22);
  endtask

  task automatic t_feb();
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h24);
    tk(); expect_reg("R5 leap 24 day", 5, 8'h29); expect_reg("R5 leap 24 month", 7, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h24);
    tk(); expect_reg("R5 leap 29 wraps", 5, 8'h01); expect_reg("R5 to march", 7, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
    tk(); expect_reg("R5 plain 23", 5, 8'h01); expect_reg("R5 plain 23 month", 7, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h10);
    tk(); expect_reg("R5 year 10 not leap", 5, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h12);
    tk(); expect_reg("R5 year 12 leap", 5, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h00);
    tk(); expect_reg("R5 year 00 leap", 5, 8'h29);
  endtask

  task automatic t_halt();
    set_time(8'h10, 8'h20, 8'h05, 8'h07, 8'h01, 8'h06, 8'h30);
    wr(0, 8'h20);
    tk(); tk(); tk();
    expect_reg("R8 halted sec", 2, 8'h10); expect_reg("R8 halted min", 3, 8'h20);
    wr(0, 8'h00);
    tk(); expect_reg("R9 absorbed after release", 2, 8'h10);
    tk(); expect_reg("R9 counting resumes", 2, 8'h11);
    tk(); expect_reg("R9 counting continues", 2, 8'h12);
  endtask

  task automatic t_valid();
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h05);
    expect_reg("R10 cleared by load", 2, 8'h30);
    @(negedge clk); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    expect_reg("R10 flag set", 2, 8'hB0); expect_reg("R10 min intact", 3, 8'h00);
    tk(); expect_reg("R10 still counting", 2, 8'hB1);
    wr(2, 8'hC5); expect_reg("R10 write clears", 2, 8'h45);
    @(negedge clk); pwr_fail = 1; wr_en = 1; addr = 4'd2; wdata = 8'h07;
    @(negedge clk); pwr_fail = 0; wr_en = 0;
    expect_reg("R10 fail wins", 2, 8'h87);
    wr(2, 8'h07);
  endtask

  task automatic t_tick_write();
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h05);
    @(negedge clk); tick_1hz = 1; wr_en = 1; addr = 4'd3; wdata = 8'h33;
    @(negedge clk); tick_1hz = 0; wr_en = 0;
    expect_reg("R11 tick dropped", 2, 8'h20); expect_reg("R11 write taken", 3, 8'h33);
    tk(); expect_reg("R11 next tick counts", 2, 8'h21);
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_full_wrap();
    t_minute_carry();
    t_month_len();
    t_feb();
    t_halt();
    t_valid();
    t_tick_write();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule